// File: doc/BRIEF.md
# Multi-Granule Stage-1 Translation Walk Sequencer

This block turns a 64-bit virtual address into an output address by walking in-memory lookup tables one level at a time. Each request carries the virtual address, a granule field (4KB, 16KB or 64KB pages), a size field that trims the usable input width, the physical base of the first table, a flag that selects whether the address belongs to the upper (all-ones-prefixed) or lower (zero-prefixed) range, and a translation enable. The sequencer works out which level the walk begins at and issues one descriptor fetch per level. Each fetch address is the current table base plus eight times the index field that the virtual address supplies for that level. The walk ends on a leaf descriptor, which gives the output address, or on a fault.

The usable input width is 64 minus the size field, capped by the granule. Levels whose index field lies wholly above that width are skipped, so the number of fetches changes with the configuration. When translation is disabled, the input address is returned unchanged and nothing is fetched. Only one walk runs at a time. The result stays on the outputs until the consumer takes it.

Top module: `xlat_walk_seq`

## Requirements
- R1: After reset `req_ready`=1, `rd_valid`=0 and `res_valid`=0. `req_ready` is 0 from the cycle a request is accepted until its result has been taken, so only one walk is in flight.
- R2: The granule field is decoded by range. In the lower range 00=4KB, 01=64KB, 10=16KB and 11 falls back to 4KB. In the upper range 01=16KB, 10=4KB, 11=64KB and 00 falls back to 4KB.
- R3: The input width W is 64 minus `req_tsz`, capped at 48 for 4KB and 16KB and at 52 for 64KB.
- R4: The walk starts at the lowest-numbered level whose index field's lowest bit is below W, or at level 3 if there is none. For example, 4KB with tsz=32 starts at level 1, and with tsz=34 it starts at level 2.
- R5: Per level, the index field is 9/11/13 bits wide above a 12/14/16-bit page offset for 4KB/16KB/64KB, with level 3 lowest. For 4KB, level 0 uses VA[47:39]. The fetch address is the table base + 8 × index.
- R6: A translating request faults at once and issues no fetch if its bits at and above W are not all zero (lower range) or not all ones (upper range). It returns `res_code`=1, with `res_level` equal to the start level and `res_addr`=0.
- R7: A descriptor with bit 0 = 0 ends the walk with `res_code`=2 and `res_level` equal to the current level. At levels 0–2, bit 1 = 1 marks a table: its bits [51:page offset] become the next base and the walk moves down one level.
- R8: Leaves are a page (bit1=1) at level 3 or a block (bit1=0) at levels 1–2. A leaf gives `res_code`=0 and `res_addr` = descriptor address bits above the level's low bit, joined with the VA bits below it. Bit1=0 at level 0 or level 3 gives `res_code`=2. Descriptor addresses are limited to 48 bits except for 64KB, which allows 52 bits.
- R9: With `req_en`=0 the result is `res_addr`=`req_va`, `res_code`=0 and `res_level`=0, and no fetch is issued.
- R10: While `res_valid`=1 and `res_ready`=0, the result outputs hold steady. Likewise, a pending fetch holds `rd_addr` until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_en | input | 1 | Translation enabled; 0 gives identity mapping |
| req_upper | input | 1 | Address belongs to the upper range |
| req_tg | input | 2 | Granule field, encoding per range (R2) |
| req_tsz | input | 6 | Size field; width is 64 minus this |
| req_base | input | 52 | Physical base of the first table |
| req_va | input | 64 | Virtual address |
| rd_valid | output | 1 | Descriptor fetch request |
| rd_ready | input | 1 | Memory accepts the fetch |
| rd_addr | output | 52 | Descriptor fetch address |
| dsc_valid | input | 1 | Descriptor returned |
| dsc_ready | output | 1 | Sequencer waits for a descriptor |
| dsc_data | input | 52 | Descriptor bits 51:0 (attribute bits not carried) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 64 | Output address |
| res_code | output | 2 | 0 ok, 1 range fault, 2 translation fault |
| res_level | output | 2 | Level at which the walk ended |

## Verification
The assertions assume the request fields stay constant while `req_valid` is high and unaccepted. They also assume a descriptor arrives only after its fetch was accepted, and that `dsc_valid` drops once the descriptor is taken. The bench's memory model answers each accepted fetch exactly once, a cycle or more later, from a table image it loaded beforehand. The request driver holds all fields until `req_ready` is seen high at a clock edge. Table bases and descriptor address fields are kept aligned to the granule in use, which the fetch and leaf arithmetic relies on.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W   = 64;
  localparam int OA_W   = 52;
  localparam int TSZ_W  = 6;
  localparam int WID_W  = 7;
  localparam int LVL_W  = 2;
  localparam int DSC_SH = 3;
  localparam int LAST_LVL = 3;

  typedef enum logic [1:0] {GR_4K = 2'd0, GR_16K = 2'd1, GR_64K = 2'd2} gran_e;
  typedef enum logic [1:0] {FC_NONE = 2'd0, FC_RANGE = 2'd1, FC_XLAT = 2'd2} fcode_e;
  typedef enum logic [1:0] {DK_FAULT = 2'd0, DK_TABLE = 2'd1, DK_LEAF = 2'd2} dkind_e;

  function automatic gran_e gran_from_lower(input logic [1:0] tg);
    case (tg)
      2'b01:   return GR_64K;
      2'b10:   return GR_16K;
      default: return GR_4K;
    endcase
  endfunction

  function automatic gran_e gran_from_upper(input logic [1:0] tg);
    case (tg)
      2'b01:   return GR_16K;
      2'b11:   return GR_64K;
      default: return GR_4K;
    endcase
  endfunction

  function automatic int gran_off(input gran_e g);
    case (g)
      GR_16K:  return 14;
      GR_64K:  return 16;
      default: return 12;
    endcase
  endfunction

  function automatic int gran_bits(input gran_e g);
    return gran_off(g) - DSC_SH;
  endfunction

  function automatic int gran_cap(input gran_e g);
    return (g == GR_64K) ? 52 : 48;
  endfunction

  function automatic logic [WID_W-1:0] lvl_low(input gran_e g, input logic [LVL_W-1:0] lvl);
    int r;
    r = gran_off(g) + (LAST_LVL - int'(lvl)) * gran_bits(g);
    return WID_W'(r);
  endfunction

  function automatic logic [WID_W-1:0] eff_width(input gran_e g, input logic [TSZ_W-1:0] tsz);
    int r;
    r = VA_W - int'(tsz);
    if (r > gran_cap(g)) r = gran_cap(g);
    return WID_W'(r);
  endfunction

  function automatic logic [VA_W-1:0] low_mask(input logic [WID_W-1:0] w);
    if (int'(w) >= VA_W) return '1;
    return (VA_W'(1) << w) - VA_W'(1);
  endfunction

  function automatic logic [LVL_W-1:0] first_level(input gran_e g, input logic [WID_W-1:0] w);
    logic [LVL_W-1:0] r;
    r = LVL_W'(LAST_LVL);
    for (int l = LAST_LVL; l >= 0; l--) begin
      if (lvl_low(g, LVL_W'(l)) < w) r = LVL_W'(l);
    end
    return r;
  endfunction
endpackage

// File: rtl/xw_cfg_decode.sv
module xw_cfg_decode
  import xw_pkg::*;
(
  input  logic             upper,
  input  logic [1:0]       tg,
  input  logic [TSZ_W-1:0] tsz,
  input  logic [VA_W-1:0]  va,
  output gran_e            gran,
  output logic [LVL_W-1:0] start_lvl,
  output logic             range_ok,
  output logic [VA_W-1:0]  va_low
);
  logic [WID_W-1:0] width;
  logic [VA_W-1:0]  keep;
  logic [VA_W-1:0]  hi_bits;

  always_comb begin
    gran      = upper ? gran_from_upper(tg) : gran_from_lower(tg);
    width     = eff_width(gran, tsz);
    start_lvl = first_level(gran, width);
    keep      = low_mask(width);
    hi_bits   = va & ~keep;
    range_ok  = upper ? (hi_bits == ~keep) : (hi_bits == '0);
    va_low    = va & keep;
  end
endmodule

// File: rtl/xw_index_gen.sv
module xw_index_gen
  import xw_pkg::*;
(
  input  gran_e            gran,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va_low,
  input  logic [OA_W-1:0]  base,
  output logic [OA_W-1:0]  fetch_addr
);
  logic [VA_W-1:0] shifted;
  logic [VA_W-1:0] index;

  always_comb begin
    shifted    = va_low >> lvl_low(gran, lvl);
    index      = shifted & low_mask(WID_W'(gran_bits(gran)));
    fetch_addr = base + {index[OA_W-DSC_SH-1:0], {DSC_SH{1'b0}}};
  end
endmodule

// File: rtl/xw_desc_eval.sv
module xw_desc_eval
  import xw_pkg::*;
(
  input  gran_e            gran,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va_low,
  input  logic [OA_W-1:0]  desc,
  output dkind_e           kind,
  output logic [OA_W-1:0]  next_base,
  output logic [OA_W-1:0]  leaf_addr
);
  logic [VA_W-1:0] field;
  logic [VA_W-1:0] below;
  logic [VA_W-1:0] joined;
  logic            is_valid;
  logic            is_tbl;

  always_comb begin
    is_valid  = desc[0];
    is_tbl    = desc[1];
    field     = {{(VA_W-OA_W){1'b0}}, desc}
              & ~low_mask(WID_W'(gran_off(gran)))
              & low_mask(WID_W'(gran_cap(gran)));
    below     = low_mask(lvl_low(gran, lvl));
    joined    = (field & ~below) | (va_low & below);
    next_base = field[OA_W-1:0];
    leaf_addr = joined[OA_W-1:0];
    if (!is_valid) begin
      kind = DK_FAULT;
    end else if (int'(lvl) == LAST_LVL) begin
      kind = is_tbl ? DK_LEAF : DK_FAULT;
    end else if (is_tbl) begin
      kind = DK_TABLE;
    end else begin
      kind = (lvl == '0) ? DK_FAULT : DK_LEAF;
    end
  end
endmodule

// File: rtl/xlat_walk_seq.sv
module xlat_walk_seq
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_en,
  input  logic             req_upper,
  input  logic [1:0]       req_tg,
  input  logic [TSZ_W-1:0] req_tsz,
  input  logic [OA_W-1:0]  req_base,
  input  logic [VA_W-1:0]  req_va,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [OA_W-1:0]  rd_addr,
  input  logic             dsc_valid,
  output logic             dsc_ready,
  input  logic [OA_W-1:0]  dsc_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [VA_W-1:0]  res_addr,
  output logic [1:0]       res_code,
  output logic [LVL_W-1:0] res_level
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_e;

  st_e              st_q;
  gran_e            gran_q;
  logic [LVL_W-1:0] lvl_q;
  logic [OA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;

  gran_e            cfg_gran;
  logic [LVL_W-1:0] cfg_start;
  logic             cfg_ok;
  logic [VA_W-1:0]  cfg_va_low;
  dkind_e           dk;
  logic [OA_W-1:0]  dk_next;
  logic [OA_W-1:0]  dk_leaf;

  // named events for the checker
  logic ev_accept, ev_bypass, ev_range_fault, ev_walk_start;
  logic ev_desc, ev_descend, ev_leaf, ev_xlat_fault, ev_retire;

  xw_cfg_decode u_cfg (
    .upper     (req_upper),
    .tg        (req_tg),
    .tsz       (req_tsz),
    .va        (req_va),
    .gran      (cfg_gran),
    .start_lvl (cfg_start),
    .range_ok  (cfg_ok),
    .va_low    (cfg_va_low)
  );

  xw_index_gen u_idx (
    .gran       (gran_q),
    .lvl        (lvl_q),
    .va_low     (va_q),
    .base       (base_q),
    .fetch_addr (rd_addr)
  );

  xw_desc_eval u_dsc (
    .gran      (gran_q),
    .lvl       (lvl_q),
    .va_low    (va_q),
    .desc      (dsc_data),
    .kind      (dk),
    .next_base (dk_next),
    .leaf_addr (dk_leaf)
  );

  assign req_ready = (st_q == S_IDLE);
  assign rd_valid  = (st_q == S_FETCH);
  assign dsc_ready = (st_q == S_WAIT);
  assign res_valid = (st_q == S_DONE);

  assign ev_accept      = req_valid && req_ready;
  assign ev_bypass      = ev_accept && !req_en;
  assign ev_range_fault = ev_accept && req_en && !cfg_ok;
  assign ev_walk_start  = ev_accept && req_en && cfg_ok;
  assign ev_desc        = dsc_valid && dsc_ready;
  assign ev_descend     = ev_desc && (dk == DK_TABLE);
  assign ev_leaf        = ev_desc && (dk == DK_LEAF);
  assign ev_xlat_fault  = ev_desc && (dk == DK_FAULT);
  assign ev_retire      = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      gran_q    <= GR_4K;
      lvl_q     <= '0;
      base_q    <= '0;
      va_q      <= '0;
      res_addr  <= '0;
      res_code  <= FC_NONE;
      res_level <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (ev_bypass) begin
            res_addr  <= req_va;
            res_code  <= FC_NONE;
            res_level <= '0;
            st_q      <= S_DONE;
          end else if (ev_range_fault) begin
            res_addr  <= '0;
            res_code  <= FC_RANGE;
            res_level <= cfg_start;
            st_q      <= S_DONE;
          end else if (ev_walk_start) begin
            gran_q <= cfg_gran;
            lvl_q  <= cfg_start;
            base_q <= req_base;
            va_q   <= cfg_va_low;
            st_q   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (rd_ready) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (ev_descend) begin
            base_q <= dk_next;
            lvl_q  <= lvl_q + 1'b1;
            st_q   <= S_FETCH;
          end else if (ev_leaf) begin
            res_addr  <= {{(VA_W-OA_W){1'b0}}, dk_leaf};
            res_code  <= FC_NONE;
            res_level <= lvl_q;
            st_q      <= S_DONE;
          end else if (ev_xlat_fault) begin
            res_addr  <= '0;
            res_code  <= FC_XLAT;
            res_level <= lvl_q;
            st_q      <= S_DONE;
          end
        end
        default: begin
          if (ev_retire) st_q <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xw_checks.sv
module xw_checks
  import xw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [OA_W-1:0]  rd_addr,
  input logic             dsc_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [VA_W-1:0]  res_addr,
  input logic [1:0]       res_code,
  input logic [LVL_W-1:0] res_level,
  input logic             ev_bypass,
  input logic             ev_range_fault,
  input logic             ev_walk_start,
  input logic             ev_descend,
  input logic             ev_xlat_fault
);
  a_r1_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || rd_valid || dsc_ready) |-> !req_ready);

  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rd_valid, dsc_ready, res_valid}));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
                                   $stable(res_code) && $stable(res_level)));

  a_r10_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  a_r9_identity: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> (res_valid && !rd_valid && res_addr == $past(req_va) && res_code == 2'd0));

  a_r6_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_fault |=> (res_valid && !rd_valid && res_code == 2'd1 && res_addr == '0));

  a_r5_walk_fetches: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_start |=> rd_valid);

  a_r7_descend: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> (rd_valid && res_level == $past(res_level)));

  a_r7_fault_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xlat_fault |=> (res_valid && res_code == 2'd2));
endmodule

bind xlat_walk_seq xw_checks u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .req_va         (req_va),
  .rd_valid       (rd_valid),
  .rd_ready       (rd_ready),
  .rd_addr        (rd_addr),
  .dsc_ready      (dsc_ready),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_addr       (res_addr),
  .res_code       (res_code),
  .res_level      (res_level),
  .ev_bypass      (ev_bypass),
  .ev_range_fault (ev_range_fault),
  .ev_walk_start  (ev_walk_start),
  .ev_descend     (ev_descend),
  .ev_xlat_fault  (ev_xlat_fault)
);

// File: tb/sim_xlat_walk_seq.sv
module sim_xlat_walk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_en = 1'b0;
  logic        req_upper = 1'b0;
  logic [1:0]  req_tg = 2'b00;
  logic [5:0]  req_tsz = 6'd0;
  logic [51:0] req_base = '0;
  logic [63:0] req_va = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [51:0] rd_addr;
  logic        dsc_valid = 1'b0;
  logic        dsc_ready;
  logic [51:0] dsc_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_addr;
  logic [1:0]  res_code;
  logic [1:0]  res_level;

  always #4 clk = ~clk;

  xlat_walk_seq u0 (.*);

  typedef struct {
    logic [63:0] addr;
    logic [1:0]  code;
    logic [1:0]  lvl;
    int          nfetch;
    logic [51:0] first;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [51:0] mem[logic [51:0]];
  logic [51:0] pend[$];
  int          total = 0;
  int          bad = 0;
  int          nfetch = 0;
  logic [51:0] first_fetch = '0;
  logic        took_dsc = 1'b0;
  logic        stall = 1'b0;

  task automatic check(input bit ok, input string tag, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // monitor: fetch capture, descriptor handshake and result scoreboard
  always @(posedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (nfetch == 0) first_fetch = rd_addr;
      nfetch++;
      pend.push_back(rd_addr);
    end
    if (dsc_valid && dsc_ready) took_dsc = 1'b1;
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "result with no request pending");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_addr == e.addr && res_code == e.code && res_level == e.lvl, e.tag,
              $sformatf("addr/code/lvl act=%h/%0d/%0d exp=%h/%0d/%0d",
                        res_addr, res_code, res_level, e.addr, e.code, e.lvl));
        check(nfetch == e.nfetch, e.tag,
              $sformatf("fetch count act=%0d exp=%0d", nfetch, e.nfetch));
        if (e.nfetch > 0)
          check(first_fetch == e.first, e.tag,
                $sformatf("first fetch act=%h exp=%h", first_fetch, e.first));
      end
      nfetch = 0;
    end
  end

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = stall ? ~rd_ready : 1'b1;
      if (took_dsc) begin
        dsc_valid = 1'b0;
        took_dsc  = 1'b0;
      end else if (!dsc_valid && pend.size() > 0) begin
        logic [51:0] a;
        a = pend.pop_front();
        dsc_data  = mem.exists(a) ? mem[a] : 52'h0;
        dsc_valid = 1'b1;
      end
    end
  end

  task automatic walk(input bit en, input bit up, input logic [1:0] tg, input logic [5:0] tsz,
                      input logic [51:0] base, input logic [63:0] va,
                      input logic [63:0] ea, input logic [1:0] ec, input logic [1:0] el,
                      input int en_f, input logic [51:0] ef, input string tag);
    exp_t e;
    e.addr = ea; e.code = ec; e.lvl = el; e.nfetch = en_f; e.first = ef; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_en = en; req_upper = up; req_tg = tg;
    req_tsz = tsz; req_base = base; req_va = va;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    // 4KB tables
    mem[52'h01008] = 52'h02003;
    mem[52'h02018] = 52'h03003;
    mem[52'h03008] = 52'hAB_CDEF_5003;
    mem[52'h01018] = 52'h03003;
    mem[52'h01020] = 52'h4060_0001;
    // 16KB tables
    mem[52'h10010] = 52'h14003;
    mem[52'h14008] = 52'h18003;
    mem[52'h18018] = 52'h123_4567_8003;
    // 64KB tables
    mem[52'h101008] = 52'h120003;
    mem[52'h120010] = 52'h130003;
    mem[52'h130008] = 52'hF_0000_0005_0003;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rd_valid == 1'b0 && res_valid == 1'b0, "R1",
          $sformatf("reset state act=%b%b%b exp=100", req_ready, rd_valid, res_valid));

    // R9: identity mapping when disabled
    walk(0, 0, 2'b00, 6'd32, 52'h1000, 64'h1234_5678_9ABC_DEF0,
         64'h1234_5678_9ABC_DEF0, 2'd0, 2'd0, 0, 52'h0, "R9");
    // R4/R5: 4KB, tsz=32 starts at level 1, three fetches, page leaf (R8)
    walk(1, 0, 2'b00, 6'd32, 52'h1000, 64'h4060_1ABC,
         64'hAB_CDEF_5ABC, 2'd0, 2'd3, 3, 52'h1008, "R4");
    // R4: 4KB, tsz=34 starts at level 2
    walk(1, 0, 2'b00, 6'd34, 52'h1000, 64'h0060_1ABC,
         64'hAB_CDEF_5ABC, 2'd0, 2'd3, 2, 52'h1018, "R4");
    // R6: lower range bit above width set
    walk(1, 0, 2'b00, 6'd34, 52'h1000, 64'h4000_0000,
         64'h0, 2'd1, 2'd2, 0, 52'h0, "R6");
    // R2: upper range, field 10 means 4KB
    walk(1, 1, 2'b10, 6'd32, 52'h1000, 64'hFFFF_FFFF_4060_1ABC,
         64'hAB_CDEF_5ABC, 2'd0, 2'd3, 3, 52'h1008, "R2");
    // R6: upper range prefix not all ones
    walk(1, 1, 2'b10, 6'd32, 52'h1000, 64'hFFFF_0000_4060_1ABC,
         64'h0, 2'd1, 2'd1, 0, 52'h0, "R6");
    // R8: block leaf at level 2
    walk(1, 0, 2'b00, 6'd34, 52'h1000, 64'h0080_1234,
         64'h4060_1234, 2'd0, 2'd2, 1, 52'h1020, "R8");
    // R7: invalid descriptor at level 2
    walk(1, 0, 2'b00, 6'd34, 52'h1000, 64'h00A0_0000,
         64'h0, 2'd2, 2'd2, 1, 52'h1028, "R7");
    // R5: 16KB, tsz=17, start level 1, with fetch backpressure (R10)
    stall = 1'b1;
    walk(1, 0, 2'b10, 6'd17, 52'h10000, 64'h20_0200_D234,
         64'h123_4567_9234, 2'd0, 2'd3, 3, 52'h10010, "R5");
    stall = 1'b0;
    // R3: 64KB, tsz=12 gives a full 52-bit space
    walk(1, 0, 2'b01, 6'd12, 52'h100000, 64'h0008_0400_4001_0ABC,
         64'hF_0000_0005_0ABC, 2'd0, 2'd3, 3, 52'h101008, "R3");
    // R3: 4KB width capped at 48, bit 50 faults at level 0
    walk(1, 0, 2'b00, 6'd0, 52'h1000, 64'h0004_0000_0000_0000,
         64'h0, 2'd1, 2'd0, 0, 52'h0, "R3");
    // R2: lower range reserved 11 behaves as 4KB
    walk(1, 0, 2'b11, 6'd34, 52'h1000, 64'h0060_1ABC,
         64'hAB_CDEF_5ABC, 2'd0, 2'd3, 2, 52'h1018, "R2");

    // R10/R1: result held while consumer stalls
    begin
      exp_t e;
      logic [63:0] held;
      e.addr = 64'h4060_1234; e.code = 2'd0; e.lvl = 2'd2; e.nfetch = 1;
      e.first = 52'h1020; e.tag = "R10";
      res_ready = 1'b0;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_en = 1'b1; req_upper = 1'b0; req_tg = 2'b00;
      req_tsz = 6'd34; req_base = 52'h1000; req_va = 64'h0080_1234;
      forever begin
        @(posedge clk);
        if (req_ready) break;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R1", $sformatf("busy ready act=%b exp=0", req_ready));
      while (!res_valid) @(negedge clk);
      held = res_addr;
      repeat (3) @(negedge clk);
      check(res_valid == 1'b1 && res_addr == held, "R10",
            $sformatf("held act=%b/%h exp=1/%h", res_valid, res_addr, held));
      check(req_ready == 1'b0, "R1", $sformatf("ready while result held act=%b exp=0", req_ready));
      res_ready = 1'b1;
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      check(req_ready == 1'b1, "R1", $sformatf("ready after retire act=%b exp=1", req_ready));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule